// File: doc/BRIEF.md
# Test-Bus Routing Controller

This block produces the digital control lines for an analog test multiplexer. The multiplexer sits beside eight DAC channels and can steer any one of them onto one of two shared test buses, where a separate ADC reads the value back. The analog switches are outside the block. It drives only a channel select, one enable per test bus, an enable for the ground-sense return and an enable for the output-connector switch.

A host writes to the block through a simple write strobe with an address and a small data field. The top address bit picks between two spaces. A write to the channel space records the channel number from the low address bits. If test routing is on, that write also starts driving the chosen test bus together with the ground-sense line. A write to the control space loads the routing controls. When the ADC finishes a conversion it raises an end-of-convert line. This line is asynchronous to the block and is synchronized first. Its rising edge releases the bus and the ground-sense line until the next channel write.

Top module: `tbr_test_route`

## Requirements
- R1: After reset, and again after any later reset, `mux_sel` is 0, both `bus_en` bits are 0, `gnd_sense_en` is 0 and `conn_en` is 0.
- R2: A write with `host_addr[3]`=1 is a control write. It loads `host_data` bit 0 as route-enable, bit 1 as bus-select (0 selects `bus_en[0]`, 1 selects `bus_en[1]`) and bit 2 as connect. `conn_en` equals the stored connect bit from the cycle after the write.
- R3: A write with `host_addr[3]`=0 is a channel write, and `mux_sel` takes `host_addr[2:0]` one cycle later. A control write leaves `mux_sel` unchanged.
- R4: A channel write made while route-enable is 1 sets, one cycle later, exactly the `bus_en` bit named by the stored bus-select, and also sets `gnd_sense_en`.
- R5: A channel write made while route-enable is 0 leaves both `bus_en` bits and `gnd_sense_en` at 0 one cycle later, and turns off any bus that was being driven.
- R6: A rising edge on `eoc_in` clears both `bus_en` bits and `gnd_sense_en` on the third rising clock edge after the rise. Holding `eoc_in` high, lowering it, or raising it again while no bus is driven leaves them off until the next channel write.
- R7: A control write does not change `bus_en` or `gnd_sense_en`. The bus being driven keeps the bus-select value that was in force at the channel write.
- R8: When a channel write and a synchronized `eoc_in` rising edge fall in the same cycle, the write wins, and the bus is driven afterwards as R4 and R5 describe.
- R9: At most one `bus_en` bit is high at any time, and `gnd_sense_en` is high exactly when one of them is.
- R10: With `host_wr` low, the address and data inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 4 | Host address bits 4..1; bit 3 of the port chooses control space, bits 2:0 give the channel |
| host_data | input | 3 | Control field: bit 0 route-enable, bit 1 bus-select, bit 2 connect |
| eoc_in | input | 1 | Asynchronous end-of-convert from the ADC, active on rising edge |
| mux_sel | output | 3 | Channel select for the test multiplexer |
| bus_en | output | 2 | Enables for test bus 0 and test bus 1 |
| gnd_sense_en | output | 1 | Enable for the ground-sense return switch |
| conn_en | output | 1 | Connects the analog output to the external connector |

## Verification
A channel write that arms a bus and the synchronized end-of-convert edge that releases it can land in the same clock cycle. The bench provokes this by raising `eoc_in` first and placing a channel write exactly two clock edges later, so that the write and the detected edge are sampled on the same third edge. It judges the result by the bus still being driven after that edge and on the following cycle. The reverse ordering is also checked: an edge with no write in that cycle releases the bus on the expected edge and not one cycle early or late.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int NUM_CH  = 8;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int ADDR_W  = CH_W + 1;
    localparam int NUM_BUS = 2;
    localparam int CTRL_W  = 3;

    // Control field; packed order puts connect at bit 2, route at bit 0
    typedef struct packed {
        logic connect;
        logic bus_sel;
        logic route_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CHAN = 2'd1,
        ACC_CTRL = 2'd2
    } access_e;

    function automatic logic [NUM_BUS-1:0] bus_onehot(input logic sel);
        logic [NUM_BUS-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction

    function automatic access_e classify(input logic wr, input logic space);
        if (!wr)   return ACC_NONE;
        if (space) return ACC_CTRL;
        return ACC_CHAN;
    endfunction

endpackage

// File: rtl/tbr_addr_decode.sv
module tbr_addr_decode
    import tbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CTRL_W-1:0] host_data,
    output logic              chan_wr,
    output logic [CH_W-1:0]   chan_q,
    output ctrl_t             ctrl_q
);

    access_e acc;

    always_comb begin
        acc     = classify(host_wr, host_addr[ADDR_W-1]);
        chan_wr = (acc == ACC_CHAN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            ctrl_q <= '0;
        end else begin
            case (acc)
                ACC_CHAN: chan_q <= host_addr[CH_W-1:0];
                ACC_CTRL: ctrl_q <= ctrl_t'(host_data);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/tbr_eoc_sync.sv
module tbr_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic eoc_in,
    output logic eoc_rise
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= eoc_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign eoc_rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/tbr_route_ctrl.sv
module tbr_route_ctrl
    import tbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               chan_wr,
    input  ctrl_t              ctrl_q,
    input  logic               eoc_rise,
    output logic [NUM_BUS-1:0] bus_en,
    output logic               gnd_sense_en
);

    logic armed_q;
    logic bus_q;

    // A channel write takes priority over a release edge in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            bus_q   <= 1'b0;
        end else if (chan_wr) begin
            armed_q <= ctrl_q.route_en;
            bus_q   <= ctrl_q.bus_sel;
        end else if (eoc_rise) begin
            armed_q <= 1'b0;
        end
    end

    always_comb begin
        bus_en       = armed_q ? bus_onehot(bus_q) : '0;
        gnd_sense_en = armed_q;
    end

endmodule

// File: rtl/tbr_test_route.sv
module tbr_test_route
    import tbr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [CTRL_W-1:0]  host_data,
    input  logic               eoc_in,
    output logic [CH_W-1:0]    mux_sel,
    output logic [NUM_BUS-1:0] bus_en,
    output logic               gnd_sense_en,
    output logic               conn_en
);

    logic  chan_wr;
    logic  eoc_rise;
    ctrl_t ctrl_q;

    tbr_addr_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_data (host_data),
        .chan_wr   (chan_wr),
        .chan_q    (mux_sel),
        .ctrl_q    (ctrl_q)
    );

    tbr_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .eoc_in   (eoc_in),
        .eoc_rise (eoc_rise)
    );

    tbr_route_ctrl u_route (
        .clk          (clk),
        .rst          (rst),
        .chan_wr      (chan_wr),
        .ctrl_q       (ctrl_q),
        .eoc_rise     (eoc_rise),
        .bus_en       (bus_en),
        .gnd_sense_en (gnd_sense_en)
    );

    assign conn_en = ctrl_q.connect;

endmodule

// File: rtl/tbr_test_route_chk.sv
module tbr_test_route_chk
    import tbr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_wr,
    input logic [ADDR_W-1:0]  host_addr,
    input logic [CTRL_W-1:0]  host_data,
    input logic               chan_wr,
    input logic               eoc_rise,
    input logic               route_en,
    input logic               bus_sel,
    input logic [CH_W-1:0]    mux_sel,
    input logic [NUM_BUS-1:0] bus_en,
    input logic               gnd_sense_en,
    input logic               conn_en
);

    // R9
    bus_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_en) && (gnd_sense_en == (bus_en != '0)));

    // R3
    chan_latch_chk: assert property (@(posedge clk) disable iff (rst)
        chan_wr |=> mux_sel == $past(host_addr[CH_W-1:0]));

    // R3
    ctrl_keeps_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr[ADDR_W-1]) |=> $stable(mux_sel));

    // R2
    conn_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr[ADDR_W-1]) |=> conn_en == $past(host_data[2]));

    // R4
    arm_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_wr && route_en) |=> gnd_sense_en && bus_en == bus_onehot($past(bus_sel)));

    // R5
    no_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_wr && !route_en) |=> !gnd_sense_en && bus_en == '0);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (eoc_rise && !chan_wr) |=> !gnd_sense_en && bus_en == '0);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!chan_wr && !eoc_rise) |=> $stable(bus_en) && $stable(gnd_sense_en));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_wr && !eoc_rise) |=> $stable(mux_sel) && $stable(conn_en));

endmodule

bind tbr_test_route tbr_test_route_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_data    (host_data),
    .chan_wr      (chan_wr),
    .eoc_rise     (eoc_rise),
    .route_en     (ctrl_q.route_en),
    .bus_sel      (ctrl_q.bus_sel),
    .mux_sel      (mux_sel),
    .bus_en       (bus_en),
    .gnd_sense_en (gnd_sense_en),
    .conn_en      (conn_en)
);

// File: tb/tbr_test_route_bench.sv
module tbr_test_route_bench;
    import tbr_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               host_wr = 1'b0;
    logic [ADDR_W-1:0]  host_addr = '0;
    logic [CTRL_W-1:0]  host_data = '0;
    logic               eoc_in = 1'b0;
    logic [CH_W-1:0]    mux_sel;
    logic [NUM_BUS-1:0] bus_en;
    logic               gnd_sense_en;
    logic               conn_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tbr_test_route u_tbr_test_route (
        .clk          (clk),
        .rst          (rst),
        .host_wr      (host_wr),
        .host_addr    (host_addr),
        .host_data    (host_data),
        .eoc_in       (eoc_in),
        .mux_sel      (mux_sel),
        .bus_en       (bus_en),
        .gnd_sense_en (gnd_sense_en),
        .conn_en      (conn_en)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  a;
        logic [2:0]  d;
        logic [2:0]  m;
        logic [1:0]  b;
        logic        g;
        logic        c;
    } vec_t;

    // write, address, data -> expected mux, bus, gnd, conn after one edge
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'h8, 3'h5, 3'd0, 2'b00, 1'b0, 1'b1},  // R2 ctrl: route, bus0, connect
        '{1'b1, 4'h3, 3'h0, 3'd3, 2'b01, 1'b1, 1'b1},  // R4 R3 chan 3 arms bus0
        '{1'b1, 4'hA, 3'h7, 3'd3, 2'b01, 1'b1, 1'b1},  // R7 R3 ctrl bus1, drive unchanged
        '{1'b1, 4'h6, 3'h0, 3'd6, 2'b10, 1'b1, 1'b1},  // R4 chan 6 arms bus1
        '{1'b0, 4'h1, 3'h0, 3'd6, 2'b10, 1'b1, 1'b1},  // R10 no strobe
        '{1'b1, 4'hF, 3'h2, 3'd6, 2'b10, 1'b1, 1'b0},  // R2 R7 route off, disconnect
        '{1'b1, 4'h0, 3'h7, 3'd0, 2'b00, 1'b0, 1'b0},  // R5 chan 0, routing off
        '{1'b1, 4'h8, 3'h3, 3'd0, 2'b00, 1'b0, 1'b0},  // R2 route on, bus1
        '{1'b1, 4'h7, 3'h0, 3'd7, 2'b10, 1'b1, 1'b0},  // R4 chan 7 arms bus1
        '{1'b0, 4'h8, 3'h4, 3'd7, 2'b10, 1'b1, 1'b0}   // R10 no strobe on ctrl addr
    };

    task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got mux/bus/gnd/conn=%b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [6:0] outs();
        return {mux_sel, bus_en, gnd_sense_en, conn_en};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [2:0] d);
        host_wr = 1'b1; host_addr = a; host_data = d;
        step();
        host_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        check("R1 reset", outs(), 7'b0);

        for (int i = 0; i < NV; i++) begin
            host_wr = VECS[i].we; host_addr = VECS[i].a; host_data = VECS[i].d;
            step();
            host_wr = 1'b0;
            check($sformatf("R2/R3/R4/R5/R7/R10 vector %0d", i), outs(),
                  {VECS[i].m, VECS[i].b, VECS[i].g, VECS[i].c});
        end

        // R6: release on the third edge after the rise
        eoc_in = 1'b1;
        step();
        check("R6 edge1 still driven", outs(), {3'd7, 2'b10, 1'b1, 1'b0});
        step();
        check("R6 edge2 still driven", outs(), {3'd7, 2'b10, 1'b1, 1'b0});
        step();
        check("R6 edge3 released", outs(), {3'd7, 2'b00, 1'b0, 1'b0});
        repeat (4) step();
        check("R6 held high stays off", outs(), {3'd7, 2'b00, 1'b0, 1'b0});
        eoc_in = 1'b0;
        repeat (4) step();
        eoc_in = 1'b1;
        repeat (4) step();
        check("R6 second rise stays off", outs(), {3'd7, 2'b00, 1'b0, 1'b0});
        eoc_in = 1'b0;
        repeat (4) step();

        // R4 rearm on bus1 after release
        wr(4'h2, 3'h0);
        check("R4 rearm after release", outs(), {3'd2, 2'b10, 1'b1, 1'b0});

        // R8: write lands in the cycle the edge is detected
        eoc_in = 1'b1;
        step();
        step();
        wr(4'h5, 3'h0);
        check("R8 write wins over edge", outs(), {3'd5, 2'b10, 1'b1, 1'b0});
        step();
        check("R8 still driven after", outs(), {3'd5, 2'b10, 1'b1, 1'b0});
        eoc_in = 1'b0;
        repeat (4) step();

        // R8 with routing off in the collision cycle
        wr(4'h8, 3'h4);
        eoc_in = 1'b1;
        step();
        step();
        wr(4'h1, 3'h0);
        check("R8 R5 collision, routing off", outs(), {3'd1, 2'b00, 1'b0, 1'b1});
        eoc_in = 1'b0;
        repeat (4) step();

        // R9 and R1 after a later reset
        wr(4'h8, 3'h5);
        wr(4'h4, 3'h0);
        check("R9 single bus with gnd", outs(), {3'd4, 2'b01, 1'b1, 1'b1});
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 later reset", outs(), 7'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule